// File: doc/BRIEF.md
# POCSAG Codeword Error Classifier

This block takes one 32-bit paging codeword and returns a repaired copy of it along with a 3-bit code that says what kind of damage was found. In the 32-bit word, bits 31..1 hold a cyclic (31,21) block code word and bit 0 is an even parity bit over all 32 bits. The block can repair a single wrong bit, two wrong bits anywhere, and a compact three-bit burst that fits inside four adjacent positions. In every case it also repairs or reports the parity bit on its own.

A request is a one-cycle `start` with the word on `in_word`. The block first latches the word and its 10-bit syndrome. A state machine then walks a fixed list of trial error patterns, one pattern per clock, and stops at the first pattern that brings the syndrome to zero. The result appears on `out_word` and `out_class` in the same cycle that `done` pulses, and it stays there until the next result. A request that arrives while a search is running is dropped.

The controller has six states:
- IDLE waits for `start` (IDLE→ZERO).
- ZERO tests the received word as it stands (ZERO→DONE on a zero syndrome, ZERO→SINGLE otherwise).
- SINGLE tries each one-bit flip (SINGLE→DONE on a hit, SINGLE→BURST after the last position).
- BURST tries the two three-bit burst shapes at each window (BURST→DONE on an accepted hit, BURST→PAIR after the last window).
- PAIR tries each two-bit flip (PAIR→DONE on an accepted hit or after the last pair).
- DONE pulses `done` (DONE→IDLE).

Top module: `pcw_classifier`

## Requirements
- R1: The check polynomial is x^10+x^9+x^8+x^6+x^5+x^3+1, applied to bits 31..1 with bit 31 as the highest power. A word whose syndrome is zero and whose 32 bits have even parity returns class 000 and the word unchanged.
- R2: A word with a zero syndrome but odd overall parity returns class 001, with only bit 0 inverted.
- R3: A word with exactly one wrong bit among bits 31..1 and a correct parity bit returns class 010 and the original codeword.
- R4: A word with one wrong bit among bits 31..1 and a wrong bit 0 returns class 011, with both bits repaired.
- R5: A word with three wrong bits in the shape 1101 or 1011 (read from high to low) inside four adjacent positions of bits 31..1, and with bit 0 correct, returns class 101 and the original codeword. The search tests the windows from low positions upward and tests 1011 before 1101 within each window. It accepts a burst only when the received word has odd parity.
- R6: A word with two wrong bits among bits 31..1 and a correct bit 0 returns class 110 and the original codeword. A pair is accepted only when the received word has even parity.
- R7: When no pattern in the order zero, single, burst, pair gives a zero syndrome under its parity condition, the block returns class 111 and the input word unchanged.
- R8: Class 100 never appears on `out_class`.
- R9: `done` is high for exactly one cycle per accepted `start`. A `start` that arrives while a search is running is ignored and produces no extra result.
- R10: `done` follows an accepted `start` within 560 cycles.
- R11: After reset, `done`, `out_word` and `out_class` are zero. The outputs change only in a cycle where `done` is high and hold their value until then.
- R12: Every result of a class other than 111 is a valid codeword: zero syndrome and even parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; accepted only when idle |
| in_word | input | 32 | Received codeword, sampled with `start` |
| done | output | 1 | One-cycle result strobe |
| out_word | output | 32 | Repaired word (or the input word when class is 111) |
| out_class | output | 3 | Error class code |

## Verification
Most faults in the search state show up as a wrong class or a wrong repaired word on the `done` cycle of the same request. Examples are a trial counter that skips or repeats a position, a burst shape tested in the wrong order, or a parity condition applied in the wrong phase. A pattern accepted by mistake also yields a non-codeword result at that same moment. A controller that stalls or loops shows only as a missing `done`, so the 560-cycle bound is the earliest point where it can be seen. An idle/busy flag that is out of step shows as an extra or lost `done` when a second request arrives mid-search.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

    localparam int WORD_W     = 32;
    localparam int SYN_W      = 10;
    localparam int IDX_W      = $clog2(WORD_W);
    localparam int FIRST_BIT  = 1;
    localparam int LAST_BIT   = WORD_W - 1;
    localparam int BURST_LEN  = 4;
    localparam int LAST_BURST = LAST_BIT - BURST_LEN + 1;

    localparam logic [SYN_W:0] GEN_POLY = 11'b111_0110_1001;

    typedef enum logic [2:0] {
        CLS_CLEAN      = 3'b000,
        CLS_PAR_ONLY   = 3'b001,
        CLS_SINGLE     = 3'b010,
        CLS_SINGLE_PAR = 3'b011,
        CLS_BURST_PAR  = 3'b101,
        CLS_DOUBLE     = 3'b110,
        CLS_FAIL       = 3'b111
    } cls_t;

    // Syndrome contribution of word bit pos: x^(pos-1) mod g. Bit 0 adds nothing.
    function automatic logic [SYN_W-1:0] column(input int pos);
        logic [SYN_W-1:0] r;
        r = (pos > 0) ? SYN_W'(1) : '0;
        for (int i = 1; i < WORD_W; i++) begin
            if (i < pos) begin
                r = {r[SYN_W-2:0], 1'b0} ^ (r[SYN_W-1] ? GEN_POLY[SYN_W-1:0] : '0);
            end
        end
        return r;
    endfunction

    function automatic logic [SYN_W-1:0] syndrome(input logic [WORD_W-1:0] w);
        logic [SYN_W-1:0] s;
        s = '0;
        for (int k = FIRST_BIT; k < WORD_W; k++) begin
            if (w[k]) s = s ^ column(k);
        end
        return s;
    endfunction

endpackage

// File: rtl/pcw_syndrome.sv
module pcw_syndrome
    import pcw_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [SYN_W-1:0]  syn,
    output logic              odd
);

    always_comb begin
        syn = syndrome(word);
        odd = ^word;
    end

endmodule

// File: rtl/pcw_trial.sv
module pcw_trial
    import pcw_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_a,
    input  logic [IDX_W-1:0]  idx_b,
    input  logic [IDX_W-1:0]  idx_c,
    output logic [SYN_W-1:0]  trial_syn,
    output logic [WORD_W-1:0] flip_mask
);

    logic [SYN_W-1:0] col_tab [WORD_W];

    for (genvar k = 0; k < WORD_W; k++) begin : g_bit
        assign col_tab[k] = column(k);
        if (k == 0) begin : g_par
            assign flip_mask[k] = 1'b0;
        end else begin : g_data
            assign flip_mask[k] = (idx_a == IDX_W'(k)) |
                                  (idx_b == IDX_W'(k)) |
                                  (idx_c == IDX_W'(k));
        end
    end

    assign trial_syn = col_tab[idx_a] ^ col_tab[idx_b] ^ col_tab[idx_c];

endmodule

// File: rtl/pcw_search_fsm.sv
module pcw_search_fsm
    import pcw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hit,
    input  logic             odd_q,
    output logic             capture,
    output logic [IDX_W-1:0] idx_a,
    output logic [IDX_W-1:0] idx_b,
    output logic [IDX_W-1:0] idx_c,
    output logic             done,
    output logic             fin_en,
    output cls_t             fin_cls,
    output logic             fin_mask_en,
    output logic             fin_par
);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZERO,
        ST_SINGLE,
        ST_BURST,
        ST_PAIR,
        ST_DONE
    } state_t;

    localparam logic [IDX_W-1:0] P_FIRST  = IDX_W'(FIRST_BIT);
    localparam logic [IDX_W-1:0] P_LAST   = IDX_W'(LAST_BIT);
    localparam logic [IDX_W-1:0] P_LASTB  = IDX_W'(LAST_BURST);
    localparam logic [IDX_W-1:0] P_LASTA  = IDX_W'(LAST_BIT - 1);
    localparam logic [IDX_W-1:0] P_ONE    = IDX_W'(1);
    localparam logic [IDX_W-1:0] P_TWO    = IDX_W'(2);
    localparam logic [IDX_W-1:0] P_TOP    = IDX_W'(BURST_LEN - 1);

    state_t           state, nxt;
    logic [IDX_W-1:0] pos_a, pos_b;
    logic             shape;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Trial position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_a <= '0;
            pos_b <= '0;
            shape <= 1'b0;
        end else begin
            unique case (state)
                ST_ZERO: pos_a <= P_FIRST;
                ST_SINGLE: begin
                    if (pos_a == P_LAST) begin
                        pos_a <= P_FIRST;
                        shape <= 1'b0;
                    end else begin
                        pos_a <= pos_a + P_ONE;
                    end
                end
                ST_BURST: begin
                    if (shape) begin
                        shape <= 1'b0;
                        if (pos_a == P_LASTB) begin
                            pos_a <= P_FIRST;
                            pos_b <= P_FIRST + P_ONE;
                        end else begin
                            pos_a <= pos_a + P_ONE;
                        end
                    end else begin
                        shape <= 1'b1;
                    end
                end
                ST_PAIR: begin
                    if (pos_b == P_LAST) begin
                        pos_a <= pos_a + P_ONE;
                        pos_b <= pos_a + P_TWO;
                    end else begin
                        pos_b <= pos_b + P_ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    // Next state and result selection
    always_comb begin
        nxt         = state;
        fin_en      = 1'b0;
        fin_cls     = CLS_CLEAN;
        fin_mask_en = 1'b0;
        fin_par     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = ST_ZERO;
            end
            ST_ZERO: begin
                if (hit) begin
                    fin_en  = 1'b1;
                    fin_cls = odd_q ? CLS_PAR_ONLY : CLS_CLEAN;
                    fin_par = odd_q;
                    nxt     = ST_DONE;
                end else begin
                    nxt = ST_SINGLE;
                end
            end
            ST_SINGLE: begin
                if (hit) begin
                    fin_en      = 1'b1;
                    fin_mask_en = 1'b1;
                    fin_cls     = odd_q ? CLS_SINGLE : CLS_SINGLE_PAR;
                    fin_par     = !odd_q;
                    nxt         = ST_DONE;
                end else if (pos_a == P_LAST) begin
                    nxt = ST_BURST;
                end
            end
            ST_BURST: begin
                if (hit && odd_q) begin
                    fin_en      = 1'b1;
                    fin_mask_en = 1'b1;
                    fin_cls     = CLS_BURST_PAR;
                    nxt         = ST_DONE;
                end else if (pos_a == P_LASTB && shape) begin
                    nxt = ST_PAIR;
                end
            end
            ST_PAIR: begin
                if (hit && !odd_q) begin
                    fin_en      = 1'b1;
                    fin_mask_en = 1'b1;
                    fin_cls     = CLS_DOUBLE;
                    nxt         = ST_DONE;
                end else if (pos_a == P_LASTA && pos_b == P_LAST) begin
                    fin_en  = 1'b1;
                    fin_cls = CLS_FAIL;
                    nxt     = ST_DONE;
                end
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs: trial indices and strobes
    always_comb begin
        idx_a   = '0;
        idx_b   = '0;
        idx_c   = '0;
        done    = (state == ST_DONE);
        capture = (state == ST_IDLE) && start;
        unique case (state)
            ST_SINGLE: idx_a = pos_a;
            ST_BURST: begin
                idx_a = pos_a;
                idx_b = pos_a + P_TOP;
                idx_c = shape ? (pos_a + P_TWO) : (pos_a + P_ONE);
            end
            ST_PAIR: begin
                idx_a = pos_a;
                idx_b = pos_b;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pcw_classifier.sv
module pcw_classifier
    import pcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] in_word,
    output logic              done,
    output logic [WORD_W-1:0] out_word,
    output logic [2:0]        out_class
);

    logic [SYN_W-1:0]  in_syn, syn_q, trial_syn;
    logic              in_odd, odd_q;
    logic [WORD_W-1:0] word_q, flip_mask;
    logic [IDX_W-1:0]  idx_a, idx_b, idx_c;
    logic              capture, hit, fin_en, fin_mask_en, fin_par;
    cls_t              fin_cls;

    pcw_syndrome u_syn (
        .word (in_word),
        .syn  (in_syn),
        .odd  (in_odd)
    );

    pcw_trial u_trial (
        .idx_a     (idx_a),
        .idx_b     (idx_b),
        .idx_c     (idx_c),
        .trial_syn (trial_syn),
        .flip_mask (flip_mask)
    );

    pcw_search_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .hit         (hit),
        .odd_q       (odd_q),
        .capture     (capture),
        .idx_a       (idx_a),
        .idx_b       (idx_b),
        .idx_c       (idx_c),
        .done        (done),
        .fin_en      (fin_en),
        .fin_cls     (fin_cls),
        .fin_mask_en (fin_mask_en),
        .fin_par     (fin_par)
    );

    assign hit = (syn_q == trial_syn);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            syn_q  <= '0;
            odd_q  <= 1'b0;
        end else if (capture) begin
            word_q <= in_word;
            syn_q  <= in_syn;
            odd_q  <= in_odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_class <= '0;
        end else if (fin_en) begin
            out_word  <= word_q ^ (fin_mask_en ? flip_mask : '0)
                                ^ {{(WORD_W-1){1'b0}}, fin_par};
            out_class <= fin_cls;
        end
    end

endmodule

// File: rtl/pcw_classifier_chk.sv
module pcw_classifier_chk
    import pcw_pkg::*;
#(
    parameter int LIMIT = 560
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [WORD_W-1:0] in_word,
    input logic              done,
    input logic [WORD_W-1:0] out_word,
    input logic [2:0]        out_class
);

    localparam int CNT_W = $clog2(LIMIT + 1) + 1;

    logic              pending;
    logic [WORD_W-1:0] cap_word;
    logic [CNT_W-1:0]  wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            cap_word <= '0;
            wait_cnt <= '0;
        end else if (done) begin
            pending <= 1'b0;
        end else if (start && !pending) begin
            pending  <= 1'b1;
            cap_word <= in_word;
            wait_cnt <= '0;
        end else if (pending) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    a_r8_no_class_100: assert property (@(posedge clk) disable iff (!rst_n)
        out_class != 3'b100);

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pending);

    a_r10_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (wait_cnt < CNT_W'(LIMIT)));

    a_r11_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({out_word, out_class}) |-> done);

    a_r7_fail_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (done && out_class == 3'b111) |-> (out_word == cap_word));

    a_r12_result_is_codeword: assert property (@(posedge clk) disable iff (!rst_n)
        (done && out_class != 3'b111) |-> (syndrome(out_word) == '0 && !(^out_word)));

endmodule

bind pcw_classifier pcw_classifier_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_word   (in_word),
    .done      (done),
    .out_word  (out_word),
    .out_class (out_class)
);

// File: tb/pcw_classifier_tb.sv
module pcw_classifier_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] in_word = '0;
    logic        done;
    logic [31:0] out_word;
    logic [2:0]  out_class;

    int checks = 0;
    int fails = 0;
    int issued = 0;
    int seen = 0;
    int cyc = 0;

    logic [31:0] exp_w_q[$];
    logic [2:0]  exp_c_q[$];
    string       tag_q[$];
    int          t0_q[$];

    pcw_classifier u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_word   (in_word),
        .done      (done),
        .out_word  (out_word),
        .out_class (out_class)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    // Long division of bits 31..1 by 11'h769
    function automatic logic [9:0] rem_of(input logic [31:0] w);
        logic [30:0] v;
        v = w[31:1];
        for (int i = 30; i >= 10; i--) begin
            if (v[i]) v[i -: 11] = v[i -: 11] ^ 11'h769;
        end
        return v[9:0];
    endfunction

    function automatic logic [31:0] encode(input logic [20:0] info);
        logic [31:0] w;
        w = {info, 11'b0};
        w[10:1] = rem_of(w);
        w[0] = ^w[31:1];
        return w;
    endfunction

    function automatic logic [31:0] bit_at(input int k);
        return 32'(1) << k;
    endfunction

    // Reference model of the search order in the requirements
    function automatic logic [34:0] model(input logic [31:0] r);
        logic odd;
        logic [31:0] e;
        odd = ^r;
        if (rem_of(r) == 0) return {odd ? 3'd1 : 3'd0, r ^ {31'b0, odd}};
        for (int k = 1; k < 32; k++) begin
            e = bit_at(k);
            if (rem_of(r ^ e) == 0) return {odd ? 3'd2 : 3'd3, r ^ e ^ {31'b0, !odd}};
        end
        if (odd) begin
            for (int p = 1; p <= 28; p++) begin
                for (int s = 0; s < 2; s++) begin
                    e = bit_at(p) | bit_at(p + 3) | bit_at(s != 0 ? p + 2 : p + 1);
                    if (rem_of(r ^ e) == 0) return {3'd5, r ^ e};
                end
            end
        end else begin
            for (int a = 1; a < 31; a++) begin
                for (int b = a + 1; b < 32; b++) begin
                    e = bit_at(a) | bit_at(b);
                    if (rem_of(r ^ e) == 0) return {3'd6, r ^ e};
                end
            end
        end
        return {3'd7, r};
    endfunction

    function automatic string tag_for(input logic [2:0] c);
        case (c)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd5: return "R5";
            3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_c_q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 64'(out_class), 64'h0);
            end else begin
                logic [31:0] ew;
                logic [2:0]  ec;
                string       tg;
                int          t0;
                ew = exp_w_q.pop_front();
                ec = exp_c_q.pop_front();
                tg = tag_q.pop_front();
                t0 = t0_q.pop_front();
                chk(out_class == ec, {tg, " class"}, 64'(out_class), 64'(ec));
                chk(out_word == ew, {tg, " word"}, 64'(out_word), 64'(ew));
                chk(out_class != 3'b100, "R8 class 100", 64'(out_class), 64'h0);
                if (out_class != 3'b111)
                    chk(rem_of(out_word) == 0 && !(^out_word), "R12 codeword",
                        64'(out_word), 64'(ew));
                chk((cyc - t0) <= 560, "R10 latency", 64'(cyc - t0), 64'd560);
                seen++;
            end
        end
    end

    task automatic launch(input logic [31:0] w);
        @(negedge clk);
        start = 1'b1;
        in_word = w;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send(input logic [31:0] w, input logic [31:0] ew, input logic [2:0] ec, input string tg);
        logic [31:0] hold_w;
        logic [2:0]  hold_c;
        exp_w_q.push_back(ew);
        exp_c_q.push_back(ec);
        tag_q.push_back(tg);
        t0_q.push_back(cyc);
        issued++;
        launch(w);
        wait (seen == issued);
        hold_w = out_word;
        hold_c = out_class;
        repeat (3) @(negedge clk);
        chk(out_word == hold_w && out_class == hold_c, "R11 hold",
            {out_word, 29'b0, out_class}, {hold_w, 29'b0, hold_c});
    endtask

    task automatic send_model(input logic [31:0] w);
        logic [34:0] m;
        m = model(w);
        send(w, m[31:0], m[34:32], tag_for(m[34:32]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", seen, issued);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] cw;
        int found;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && out_word == '0 && out_class == '0, "R11 reset",
            {out_word, 29'b0, out_class, done}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: clean codewords
        send(encode(21'h0), encode(21'h0), 3'd0, "R1");
        cw = encode(21'h1A5C3);
        send(cw, cw, 3'd0, "R1");
        cw = encode(21'h1FFFFF);
        send(cw, cw, 3'd0, "R1");

        // R2: parity bit only
        cw = encode(21'h0B00F);
        send(cw ^ 32'h1, cw, 3'd1, "R2");

        // R3: single error, parity right
        cw = encode(21'h12345);
        send(cw ^ bit_at(1), cw, 3'd2, "R3");
        send(cw ^ bit_at(17), cw, 3'd2, "R3");
        send(cw ^ bit_at(31), cw, 3'd2, "R3");

        // R4: single error plus parity error
        cw = encode(21'h0F0F0);
        send(cw ^ bit_at(5) ^ 32'h1, cw, 3'd3, "R4");
        send(cw ^ bit_at(31) ^ 32'h1, cw, 3'd3, "R4");

        // R5: bursts 1101 at window 1 and 1011 at window 2
        cw = encode(21'h0AAAA);
        send(cw ^ bit_at(4) ^ bit_at(3) ^ bit_at(1), cw, 3'd5, "R5");
        send(cw ^ bit_at(5) ^ bit_at(3) ^ bit_at(2), cw, 3'd5, "R5");
        for (int p = 6; p <= 28; p += 11) send_model(cw ^ bit_at(p + 3) ^ bit_at(p + 2) ^ bit_at(p));

        // R6: double errors
        cw = encode(21'h15555);
        send(cw ^ bit_at(1) ^ bit_at(2), cw, 3'd6, "R6");
        send(cw ^ bit_at(1) ^ bit_at(31), cw, 3'd6, "R6");
        send(cw ^ bit_at(10) ^ bit_at(20), cw, 3'd6, "R6");

        // R9: second start during a long search is ignored
        cw = encode(21'h07777);
        exp_w_q.push_back(cw);
        exp_c_q.push_back(3'd6);
        tag_q.push_back("R9 busy");
        t0_q.push_back(cyc);
        issued++;
        launch(cw ^ bit_at(29) ^ bit_at(30));
        repeat (3) @(negedge clk);
        launch(encode(21'h1));
        wait (seen == issued);
        repeat (10) @(negedge clk);
        chk(seen == issued, "R9 single result", 64'(seen), 64'(issued));

        // R7: uncorrectable words found by the reference model
        found = 0;
        for (int n = 0; n < 400 && found < 3; n++) begin
            logic [31:0] r;
            logic [34:0] m;
            r = $urandom;
            m = model(r);
            if (m[34:32] == 3'd7) begin
                send(r, r, 3'd7, "R7");
                found++;
            end
        end
        chk(found == 3, "R7 cases found", 64'(found), 64'd3);

        // Mixed damage against the reference model
        for (int n = 0; n < 16; n++) begin
            logic [31:0] r;
            r = encode(21'($urandom)) ^ bit_at(1 + ($urandom % 31));
            if (n % 2 == 1) r = r ^ bit_at(1 + ($urandom % 31));
            if (n % 4 == 3) r = r ^ 32'h1;
            send_model(r);
        end

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule